// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles and returns a quotient and a remainder of the same width as the operands. A pulse on `start` while the block is idle captures both operands. The dividend goes into the low half of a remainder register that is twice the operand width. The divisor goes into the upper half of a divisor register of the same double width. The quotient register is cleared at the same time.

Each iteration makes a trial subtraction of the divisor register from the remainder register. The borrow out of that subtraction decides whether the difference is kept or the old remainder is restored. The inverse of the borrow is shifted into the low end of the quotient, and the divisor register then moves one place to the right. After one iteration more than the operand width, `done` pulses for one cycle and the results are valid. A zero divisor is reported through a flag and produces a defined result.

Top module: `restoring_divider`

## Requirements
- R1: When a run with a non-zero divisor ends, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, with both operands treated as unsigned.
- R2: A `start` seen high at a rising edge while `busy` is low captures `dividend` and `divisor`, and `busy` is high in the next cycle. Operand values presented after that edge have no effect on the run.
- R3: `busy` stays high for exactly DATA_W+1 consecutive cycles per run, which is 33 for the default width of 32.
- R4: `done` is high for exactly one cycle. That cycle is the first one with `busy` low after a run, and the results are valid in it.
- R5: A `start` pulse while `busy` is high is ignored. The run in progress keeps its timing and its result.
- R6: A zero divisor makes `div_by_zero` high at `done`, with `quotient` all ones and `remainder` equal to the dividend. A run with a non-zero divisor leaves the flag low. The flag does not change while `busy` is high.
- R7: After k iterations, `quotient` holds floor(dividend / (divisor·2^(DATA_W+1−k))) taken modulo 2^DATA_W, and `remainder` holds dividend mod (divisor·2^(DATA_W+1−k)). Each new quotient bit is 1 exactly when the trial difference is non-negative. A zero divisor gives k low ones in the quotient and an unchanged remainder.
- R8: After reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R9: While the block is idle and no `start` is accepted, `quotient` and `remainder` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division (taken only when idle) |
| dividend | input | DATA_W | Unsigned dividend |
| divisor | input | DATA_W | Unsigned divisor |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | DATA_W | Quotient register |
| remainder | output | DATA_W | Low half of the remainder register |
| div_by_zero | output | 1 | Set when the captured divisor was zero |

## Verification
The assertions check the handshake on every cycle. They cover acceptance of `start` only when idle, the exact run length measured by a counter in the checker, the single-cycle `done`, holding of results while idle, the stability of the zero-divisor flag during a run, and the all-ones quotient under that flag. They also check that each iteration's new quotient bit is the inverse of the trial borrow. The numeric values of the partial quotient and remainder after every iteration, the final arithmetic result, and the fact that a `start` during a run leaves the result untouched can only be shown by the bench. The bench does this with its wide-integer model across boundary operands and random operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_seq.sv
// Iteration sequencer: accepts a start when idle, counts iterations, pulses done.
module div_seq #(
  parameter int ITER = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  import div_pkg::*;

  localparam int CNT_W = $clog2(ITER + 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = busy_o;
  assign last_o = step_o && (cnt_q == CNT_W'(ITER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/div_core.sv
// Datapath: double-width remainder and divisor registers, quotient shift register.
module div_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic [DATA_W-1:0] quotient_o,
  output logic [DATA_W-1:0] remainder_o,
  output logic              borrow_o
);
  localparam int WIDE = 2 * DATA_W;

  // Trial subtraction with one extra bit; its top bit is the borrow.
  function automatic logic [WIDE:0] trial_diff(input logic [WIDE-1:0] r,
                                               input logic [WIDE-1:0] d);
    return {1'b0, r} - {1'b0, d};
  endfunction

  logic [WIDE-1:0]   rem_q;
  logic [WIDE-1:0]   dvs_q;
  logic [DATA_W-1:0] quo_q;
  logic [WIDE:0]     diff;

  assign diff        = trial_diff(rem_q, dvs_q);
  assign borrow_o    = diff[WIDE];
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      rem_q <= {{DATA_W{1'b0}}, dividend_i};
      dvs_q <= {divisor_i, {DATA_W{1'b0}}};
      quo_q <= '0;
    end else if (step_i) begin
      if (!borrow_o) rem_q <= diff[WIDE-1:0];
      quo_q <= {quo_q[DATA_W-2:0], ~borrow_o};
      dvs_q <= dvs_q >> 1;
    end
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              div_by_zero
);
  localparam int ITER = DATA_W + 1;

  // Named internal events, visible to the bound checker.
  logic load_evt;
  logic step_evt;
  logic last_evt;
  logic trial_borrow;

  div_seq #(.ITER(ITER)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .load_o  (load_evt),
    .step_o  (step_evt),
    .last_o  (last_evt),
    .busy_o  (busy),
    .done_o  (done)
  );

  div_core #(.DATA_W(DATA_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_evt),
    .step_i      (step_evt),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .quotient_o  (quotient),
    .remainder_o (remainder),
    .borrow_o    (trial_borrow)
  );

  // A zero divisor never borrows, so the datapath itself yields an all-ones
  // quotient and an untouched remainder; only the flag is kept here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_by_zero <= 1'b0;
    else if (load_evt) div_by_zero <= (divisor == '0);
  end
endmodule

// File: rtl/div_props.sv
module div_props #(
  parameter int DATA_W = 32,
  parameter int ITER   = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] quotient,
  input logic [DATA_W-1:0] remainder,
  input logic              div_by_zero,
  input logic              step_evt,
  input logic              trial_borrow
);
  localparam int LEN_W = $clog2(ITER + 1) + 1;

  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);                                              // R2
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < LEN_W'(ITER));                                      // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == LEN_W'(ITER));                                     // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                       // R4
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));                                        // R4
  AST_ZERO_QUOTIENT: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_by_zero |-> &quotient);                                    // R6
  AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_by_zero));                                        // R6
  AST_RESTORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> quotient[0] == !$past(trial_borrow));                     // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(quotient) && $stable(remainder));          // R9
endmodule

bind restoring_divider div_props #(.DATA_W(DATA_W), .ITER(DATA_W + 1)) u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .quotient     (quotient),
  .remainder    (remainder),
  .div_by_zero  (div_by_zero),
  .step_evt     (step_evt),
  .trial_borrow (trial_borrow)
);

// File: tb/restoring_divider_test.sv
module restoring_divider_test;
  localparam int W  = 32;
  localparam int NI = W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  restoring_divider #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference after k iterations, by wide integer arithmetic.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input int k,
                       output logic [W-1:0] q, output logic [W-1:0] r);
    logic [127:0] aw, den, ones;
    aw = {96'b0, a};
    if (b == '0) begin
      ones = (128'b1 << k) - 128'b1;
      q = ones[W-1:0];
      r = a;
    end else begin
      den  = {96'b0, b} << (NI - k);
      ones = aw / den;
      q = ones[W-1:0];
      ones = aw % den;
      r = ones[W-1:0];
    end
  endtask

  task automatic run_case(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    logic [W-1:0] eq, er, hq, hr;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = b ^ 32'h5A5A_0001;  // late values must not matter (R2)
    chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    model(a, b, 0, eq, er);
    chk(quotient === eq && remainder === er, "R7 k=0",
        {quotient, remainder}, {eq, er});
    for (int k = 1; k <= NI; k++) begin
      @(negedge clk);
      model(a, b, k, eq, er);
      if (k < NI) begin
        chk(busy === 1'b1 && done === 1'b0, "R3 busy during run",
            64'({busy, done}), 64'b10);
        chk(quotient === eq && remainder === er, "R7 partial result",
            {quotient, remainder}, {eq, er});
      end else begin
        chk(busy === 1'b0 && done === 1'b1, "R4 done after 33 cycles",
            64'({busy, done}), 64'b01);
        if (b == '0)
          chk(quotient === '1 && remainder === a, "R6 zero divisor result",
              {quotient, remainder}, {32'hFFFF_FFFF, a});
        else
          chk(quotient === a / b && remainder === a % b,
              poke ? "R5 start during run ignored" : "R1 final result",
              {quotient, remainder}, {a / b, a % b});
        chk(div_by_zero === (b == '0), "R6 flag", 64'(div_by_zero), 64'(b == '0));
      end
      start = (poke && k == 10);
      if (start) begin dividend = 32'd9; divisor = 32'd2; end
    end
    start = 1'b0;
    hq = quotient; hr = remainder;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R4 single-cycle done",
        64'({busy, done}), 64'b00);
    chk(quotient === hq && remainder === hr, "R9 hold after done",
        {quotient, remainder}, {hq, hr});
  endtask

  initial begin
    logic [W-1:0] hq, hr;
    repeat (3) @(negedge clk);
    chk({busy, done, div_by_zero} === 3'b000 && quotient === '0 && remainder === '0,
        "R8 state in reset", {quotient, remainder}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, div_by_zero} === 3'b000 && quotient === '0 && remainder === '0,
        "R8 state after reset", {quotient, remainder}, 64'd0);

    run_case(32'd100, 32'd7, 1'b0);
    run_case(32'hFFFF_FFFF, 32'd1, 1'b0);
    run_case(32'd5, 32'd10, 1'b0);
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_case(32'h8000_0000, 32'd3, 1'b0);
    run_case(32'h1234_5678, 32'd0, 1'b0);
    run_case(32'd0, 32'd0, 1'b0);
    run_case(32'd77, 32'd9, 1'b0);            // flag clears again (R6)
    run_case(32'hDEAD_BEEF, 32'h0001_0000, 1'b1);
    for (int i = 0; i < 20; i++) run_case($urandom, $urandom >> (i % 31), 1'b0);

    hq = quotient; hr = remainder;
    dividend = 32'h0BAD_F00D; divisor = 32'd5;
    repeat (5) @(negedge clk);
    chk(quotient === hq && remainder === hr && busy === 1'b0, "R9 idle hold",
        {quotient, remainder}, {hq, hr});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule